// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block holds the two digital divider chains that feed a phase-frequency detector in a frequency synthesizer. On the oscillator side a dual-modulus prescaler runs under a 7-bit swallow counter and an 11-bit main counter. Together they divide the fast oscillator clock by `N*P + A`. Here `P` is the lower prescaler modulus (64 or 128), `N` is the main count and `A` is the swallow count. On the reference side a 14-bit counter divides a separate reference clock by `R`.

Each chain emits one single-cycle pulse per output period in its own clock domain. The phase detector treats that pulse as the edge to compare. `fp` comes from the oscillator chain and `fr` from the reference chain.

The divide values come from registers that are already latched elsewhere. The block samples them only at its own terminal counts, so a rewrite never shortens or stretches the period in progress.

Top module: `pswallow_divider`

## Requirements
- R1: With `presc_small`=1 the prescaler moduli are 64 and 65. With `presc_small`=0 they are 128 and 129. The `fp` pulses repeat every `N*P + A` oscillator cycles.
- R2: In each output period the prescaler runs `A` cycles at `P+1` and then `N-A` cycles at `P`. This gives a period of `N*P + A` for any `A` up to `N`, including `A`=0 and `A`=`N`.
- R3: A swallow count larger than the effective main count is used as equal to it, so the period becomes `N*(P+1)`.
- R4: A main count of 0 is used as 1.
- R5: `fp` is high for exactly one oscillator cycle per period. The first pulse follows exactly one period after the first clock edge with `vco_rst` low, counted with the values present during reset.
- R6: Oscillator-side values (`main_count`, `swallow_count`, `presc_small`) are sampled only at reset and at the edge that ends a period. Changes at any other time do not alter the current period.
- R7: For ratios 8 to 16383, `fr` is high for one reference cycle every `ref_ratio` reference cycles.
- R8: A ratio below 8 gives a period of 8. `ref_ratio_clamped` is then 1 from the reload that took that ratio until a reload takes a legal ratio. The flag changes only on reloads (the edges where `fr` rises) and in reset.
- R9: `ref_ratio` is sampled only at reset and at the edge that ends a reference period.
- R10: During reset `fp` and `fr` are 0, and `ref_ratio_clamped` shows whether the current `ref_ratio` is below 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator-side clock |
| vco_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| ref_clk | input | 1 | Reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| main_count | input | 11 | Main counter value N |
| swallow_count | input | 7 | Swallow counter value A |
| presc_small | input | 1 | 1 selects 64/65, 0 selects 128/129 |
| ref_ratio | input | 14 | Reference divide ratio R |
| fp | output | 1 | Oscillator-side divided pulse |
| fr | output | 1 | Reference-side divided pulse |
| ref_ratio_clamped | output | 1 | Latched ratio was below 8 and was clamped |

## Verification
The hardest case to reach from the ports is a rewrite of the divide values that lands on the very edge that closes a period, or one cycle before or after it. That single edge decides whether the new word applies now or one period later.

The stimulus reaches this case by holding random small values of `N`, `A` and the prescaler select for random numbers of cycles. The short periods (64 to about 520 cycles) make the changes fall on every phase of a period, including the reload edge itself. The same random phases cover the `A`=`N` and `A`>`N` corners of the swallow counter and the `N`=0 corner.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    MODE_BASE  = 1'b0,
    MODE_PLUS1 = 1'b1
  } psd_mode_e;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int P_SMALL = 64,
  parameter int P_LARGE = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                small_sel,
  input  psd_pkg::psd_mode_e  mode,
  output logic                tc
);
  localparam int CW = $clog2(P_LARGE + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] base;
  logic [CW-1:0] last;

  // Last count index of the current prescaler cycle: P-1 in base mode, P in plus-one mode
  always_comb begin
    base = small_sel ? CW'(P_SMALL) : CW'(P_LARGE);
    last = (mode == psd_pkg::MODE_PLUS1) ? base : base - 1'b1;
    tc   = (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || tc) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psd_swallow_ctl.sv
module psd_swallow_ctl #(
  parameter int N_W = 11,
  parameter int A_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_W-1:0]     n_in,
  input  logic [A_W-1:0]     a_in,
  input  logic               sel_in,
  input  logic               pre_tc,
  output psd_pkg::psd_mode_e mode,
  output logic               small_sel,
  output logic               pulse
);
  localparam int CW = (N_W > A_W) ? N_W : A_W;

  logic [N_W-1:0] n_cnt;
  logic [A_W-1:0] a_cnt;
  logic [N_W-1:0] n_eff;
  logic [A_W-1:0] a_eff;
  logic [CW-1:0]  a_ext;
  logic [CW-1:0]  n_ext;
  logic           period_end;

  // Clamp: N of zero acts as one, A never exceeds N
  always_comb begin
    n_eff      = (n_in == '0) ? N_W'(1) : n_in;
    a_ext      = CW'(a_in);
    n_ext      = CW'(n_eff);
    a_eff      = (a_ext > n_ext) ? A_W'(n_ext) : a_in;
    period_end = pre_tc && (n_cnt == N_W'(1));
    mode       = (a_cnt != '0) ? psd_pkg::MODE_PLUS1 : psd_pkg::MODE_BASE;
  end

  always_ff @(posedge clk) begin
    if (rst || period_end) begin
      n_cnt     <= n_eff;
      a_cnt     <= a_eff;
      small_sel <= sel_in;
      pulse     <= !rst;
    end else begin
      pulse <= 1'b0;
      if (pre_tc) begin
        n_cnt <= n_cnt - 1'b1;
        if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div #(
  parameter int R_W   = 14,
  parameter int R_MIN = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [R_W-1:0] r_in,
  output logic           pulse,
  output logic           clamped
);
  logic [R_W-1:0] cnt;
  logic [R_W-1:0] r_eff;
  logic           r_low;

  always_comb begin
    r_low = (r_in < R_W'(R_MIN));
    r_eff = r_low ? R_W'(R_MIN) : r_in;
  end

  always_ff @(posedge clk) begin
    if (rst || cnt == '0) begin
      cnt     <= r_eff - 1'b1;
      clamped <= r_low;
      pulse   <= !rst;
    end else begin
      cnt   <= cnt - 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
  parameter int N_W     = 11,
  parameter int A_W     = 7,
  parameter int R_W     = 14,
  parameter int P_SMALL = 64,
  parameter int P_LARGE = 128,
  parameter int R_MIN   = 8
) (
  input  logic           vco_clk,
  input  logic           vco_rst,
  input  logic           ref_clk,
  input  logic           ref_rst,
  input  logic [N_W-1:0] main_count,
  input  logic [A_W-1:0] swallow_count,
  input  logic           presc_small,
  input  logic [R_W-1:0] ref_ratio,
  output logic           fp,
  output logic           fr,
  output logic           ref_ratio_clamped
);
  psd_pkg::psd_mode_e mode;
  logic               small_sel;
  logic               pre_tc;

  psd_prescaler #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE)) u_presc (
    .clk       (vco_clk),
    .rst       (vco_rst),
    .small_sel (small_sel),
    .mode      (mode),
    .tc        (pre_tc)
  );

  psd_swallow_ctl #(.N_W(N_W), .A_W(A_W)) u_swallow (
    .clk       (vco_clk),
    .rst       (vco_rst),
    .n_in      (main_count),
    .a_in      (swallow_count),
    .sel_in    (presc_small),
    .pre_tc    (pre_tc),
    .mode      (mode),
    .small_sel (small_sel),
    .pulse     (fp)
  );

  psd_ref_div #(.R_W(R_W), .R_MIN(R_MIN)) u_ref (
    .clk     (ref_clk),
    .rst     (ref_rst),
    .r_in    (ref_ratio),
    .pulse   (fr),
    .clamped (ref_ratio_clamped)
  );
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int P_SMALL = 64,
  parameter int R_MIN   = 8
) (
  input logic vco_clk,
  input logic vco_rst,
  input logic ref_clk,
  input logic ref_rst,
  input logic fp,
  input logic fr,
  input logic ref_ratio_clamped
);
  logic [31:0] vgap;
  logic [31:0] rgap;
  logic        r_live;

  always_ff @(posedge vco_clk) begin
    if (vco_rst) vgap <= '0;
    else         vgap <= fp ? 32'd1 : vgap + 32'd1;
  end

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      rgap   <= '0;
      r_live <= 1'b0;
    end else begin
      rgap   <= fr ? 32'd1 : rgap + 32'd1;
      r_live <= 1'b1;
    end
  end

  AST_FP_ONE_CYCLE: assert property (@(posedge vco_clk) disable iff (vco_rst)
    fp |=> !fp); // R5

  AST_FP_MIN_PERIOD: assert property (@(posedge vco_clk) disable iff (vco_rst)
    fp |-> (vgap >= 32'(P_SMALL))); // R1

  AST_FR_ONE_CYCLE: assert property (@(posedge ref_clk) disable iff (ref_rst)
    fr |=> !fr); // R7

  AST_FR_MIN_PERIOD: assert property (@(posedge ref_clk) disable iff (ref_rst)
    fr |-> (rgap >= 32'(R_MIN))); // R8

  AST_FLAG_ON_RELOAD: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (r_live && !$stable(ref_ratio_clamped)) |-> fr); // R8
endmodule

bind pswallow_divider psd_checker #(.P_SMALL(P_SMALL), .R_MIN(R_MIN)) u_chk (
  .vco_clk           (vco_clk),
  .vco_rst           (vco_rst),
  .ref_clk           (ref_clk),
  .ref_rst           (ref_rst),
  .fp                (fp),
  .fr                (fr),
  .ref_ratio_clamped (ref_ratio_clamped)
);

// File: tb/tb_pswallow_divider.sv
module tb_pswallow_divider;
  localparam int CLK_PERIOD = 4;
  localparam int REF_PERIOD = 3 * CLK_PERIOD;

  logic        vco_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        vco_rst = 1'b1;
  logic        ref_rst = 1'b1;
  logic [10:0] main_count = 11'd3;
  logic [6:0]  swallow_count = 7'd1;
  logic        presc_small = 1'b1;
  logic [13:0] ref_ratio = 14'd13;
  logic        fp, fr, ref_ratio_clamped;

  int    tests = 0;
  int    fails = 0;
  string vtag = "R10";
  string rtag = "R10";
  bit    v_done = 0, r_done = 0, ended = 0;

  always #(CLK_PERIOD/2) vco_clk = ~vco_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  pswallow_divider dut (
    .vco_clk(vco_clk), .vco_rst(vco_rst), .ref_clk(ref_clk), .ref_rst(ref_rst),
    .main_count(main_count), .swallow_count(swallow_count),
    .presc_small(presc_small), .ref_ratio(ref_ratio),
    .fp(fp), .fr(fr), .ref_ratio_clamped(ref_ratio_clamped)
  );

  // Period from the requirements: N of 0 acts as 1, A capped at N, P = 64 or 128
  function automatic int vco_len(int n, int a, bit s);
    int ne = (n == 0) ? 1 : n;
    int ae = (a > ne) ? ne : a;
    int p  = s ? 64 : 128;
    return ne * p + ae;
  endfunction

  function automatic int ref_len(int r);
    return (r < 8) ? 8 : r;
  endfunction

  // Behavioural reference model, oscillator side
  int   v_cnt, v_len;
  logic e_fp;
  bit   v_live = 0;
  always @(posedge vco_clk) begin
    if (vco_rst) begin
      v_cnt = 0;
      v_len = vco_len(main_count, swallow_count, presc_small);
      e_fp  = 1'b0;
    end else begin
      v_cnt++;
      if (v_cnt == v_len) begin
        e_fp  = 1'b1;
        v_cnt = 0;
        v_len = vco_len(main_count, swallow_count, presc_small);
      end else e_fp = 1'b0;
    end
    v_live = 1;
  end

  // Behavioural reference model, reference side
  int   r_cnt, r_len;
  logic e_fr, e_flag;
  bit   r_live = 0;
  always @(posedge ref_clk) begin
    if (ref_rst) begin
      r_cnt  = 0;
      r_len  = ref_len(ref_ratio);
      e_fr   = 1'b0;
      e_flag = (ref_ratio < 8);
    end else begin
      r_cnt++;
      if (r_cnt == r_len) begin
        e_fr   = 1'b1;
        r_cnt  = 0;
        r_len  = ref_len(ref_ratio);
        e_flag = (ref_ratio < 8);
      end else e_fr = 1'b0;
    end
    r_live = 1;
  end

  always @(negedge vco_clk) if (v_live && !ended) begin
    tests++;
    if (fp !== e_fp) begin
      fails++;
      $display("FAIL %s fp=%b expected %b at %0t", vtag, fp, e_fp, $time);
    end
  end

  always @(negedge ref_clk) if (r_live && !ended) begin
    tests++;
    if (fr !== e_fr) begin
      fails++;
      $display("FAIL %s fr=%b expected %b at %0t", rtag, fr, e_fr, $time);
    end
    tests++;
    if (ref_ratio_clamped !== e_flag) begin
      fails++;
      $display("FAIL %s clamped=%b expected %b at %0t", rtag, ref_ratio_clamped, e_flag, $time);
    end
  end

  task automatic vset(int n, int a, bit s, int cycles);
    @(negedge vco_clk);
    main_count = 11'(n); swallow_count = 7'(a); presc_small = s;
    repeat (cycles) @(negedge vco_clk);
  endtask

  task automatic rset(int r, int cycles);
    @(negedge ref_clk);
    ref_ratio = 14'(r);
    repeat (cycles) @(negedge ref_clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Oscillator-side stimulus
  initial begin
    repeat (3) @(negedge vco_clk);
    tests++; // R10 reset state of fp
    if (fp !== 1'b0) begin fails++; $display("FAIL R10 fp=%b expected 0", fp); end
    vco_rst = 1'b0;
    vtag = "R1 R5";  repeat (700) @(negedge vco_clk);
    vset(2, 1, 0, 800);
    vtag = "R2";     vset(5, 0, 0, 700);
    vset(4, 4, 1, 600);
    vset(4, 3, 1, 600);
    vtag = "R3";     vset(2, 5, 1, 400);
    vtag = "R4";     vset(0, 0, 1, 300);
    vset(0, 3, 1, 300);
    vtag = "R6";
    for (int i = 0; i < 60; i++)
      vset($urandom % 5, $urandom % 10, 1'($urandom % 2), 1 + ($urandom % 150));
    repeat (600) @(negedge vco_clk);
    v_done = 1;
  end

  // Reference-side stimulus
  initial begin
    repeat (3) @(negedge ref_clk);
    tests++; // R10 reset state of fr
    if (fr !== 1'b0) begin fails++; $display("FAIL R10 fr=%b expected 0", fr); end
    ref_rst = 1'b0;
    rtag = "R7";  rset(8, 60);
    rset(13, 80);
    rset(100, 300);
    rtag = "R8";  rset(3, 60);
    rset(0, 40);
    rset(20, 80);
    rtag = "R9";
    for (int i = 0; i < 40; i++) rset($urandom % 40, 1 + ($urandom % 50));
    repeat (100) @(negedge ref_clk);
    r_done = 1;
  end

  initial begin
    wait (v_done && r_done);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge vco_clk);
    fails++;
    $display("FAIL watchdog expired v_done=%0d r_done=%0d expected 1 1", v_done, r_done);
    finish_run();
  end
endmodule